// File: doc/BRIEF.md
# Fused LSTM Hidden-Unit Engine

This block computes a recurrent layer with long short-term memory cells, one hidden element at a time. For each hidden index it runs four gate dot products: input, candidate, forget and output. Each dot product takes one row of that gate's weights and the operand vector, which holds the D input features followed by the H previous hidden values. The products are formed RV elements per cycle, summed by a small adder tree and accumulated into a 32-bit scalar. The gate bias is added to this sum. The result then addresses the gate's activation table. The cell value and the hidden value follow at once from the four table outputs, so every intermediate result is a scalar register and no vector buffer is needed.

All arithmetic is signed fixed point with 8 fraction bits on 16-bit data. New hidden values go into a small shadow store. They are copied into the operand vector only after every index of the step has been computed, so all indices of one step see the same previous hidden state. Time steps run strictly one after another. A command sets the number of steps, and the block reports busy and a done pulse.

All storage sits outside the block and is reached through plain synchronous RAM ports. Read data appears in the cycle after the address was presented. These ports carry no handshake and cannot stall the block, because the engine expects every read to return in one cycle. No port of the block is a stream, so the block has no valid/ready interface and no back-pressure.

Top module: `lstm_unit_engine`

## Requirements
- R1: After reset, busy and done are 0 and neither the cell store nor the operand vector is written.
- R2: While idle, a start pulse latches num_steps and begins a run, with a num_steps of 0 run as one step. busy rises in the next cycle and stays high for exactly num_steps × H × (R/RV + 6) cycles.
- R3: A start pulse while busy is ignored: the length and the results of the run are unchanged.
- R4: Each gate pre-activation is the sum, over all R operand elements, of the full 32-bit signed weight × operand products (wrapping in 32 bits), shifted right arithmetically by 8, plus the sign-extended 16-bit bias.
- R5: A table address is the pre-activation shifted right arithmetically by SHIFT and saturated to the signed LW-bit range, given as two's-complement bits. Gate g (0 input, 1 candidate, 2 forget, 3 output) uses lane g of the packed weight, bias, table-address and table-data ports.
- R6: The new cell value is the low 16 bits of (input×candidate + old_cell×forget) shifted right arithmetically by 8. It is written once to the cell store at the same hidden index.
- R7: The new hidden value is the low 16 bits of (tanh_table[address of new cell] × output) shifted right arithmetically by 8.
- R8: New hidden values are written to operand positions D+index only after all H indices of the step are done, in ascending order. The writes go only to positions at or above D.
- R9: done is a one-cycle pulse in the cycle after the last write of the final step, with busy already low.
- R10: While idle, the block writes neither the cell store nor the operand vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| num_steps | input | SW | Number of time steps (0 runs one) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| w_row | output | HAW | Weight row (hidden index) |
| w_chunk | output | CAW | Weight chunk index |
| w_rd_data | input | 4*RV*16 | Weight chunks, gate g in lane g |
| b_addr | output | HAW | Bias address |
| b_rd_data | input | 4*16 | Biases, gate g in lane g |
| lut_addr | output | 4*LW | Activation table addresses per gate |
| lut_rd_data | input | 4*16 | Activation table outputs per gate |
| tanh_addr | output | LW | Cell tanh table address |
| tanh_rd_data | input | 16 | Cell tanh table output |
| c_rd_addr | output | HAW | Cell store read address |
| c_rd_data | input | 16 | Old cell value |
| c_wr_en | output | 1 | Cell store write enable |
| c_wr_addr | output | HAW | Cell store write address |
| c_wr_data | output | 16 | New cell value |
| xh_rd_chunk | output | CAW | Operand chunk read index |
| xh_rd_data | input | RV*16 | Operand chunk, element e in lane e |
| xh_wr_en | output | 1 | Operand write enable |
| xh_wr_addr | output | XAW | Operand write position |
| xh_wr_data | output | 16 | Hidden value to store |

## Verification
The assertions take for granted that every RAM returns its data exactly one cycle after the address and never stalls. They also assume that the storage is not changed by anything other than the engine while busy is high. The bench models all memories as one-cycle synchronous arrays. It changes their contents only between runs, and it pulses start during a run only to show that the pulse is ignored. Contents come from $urandom with a fixed seed, in small, full-range and saturating patterns, so table addresses cover the interior range and both clamp limits.

// File: rtl/lstm_pkg.sv
package lstm_pkg;
  localparam int DW   = 16;
  localparam int FRAC = 8;
  localparam int AW   = 32;
  localparam int NG   = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_DOT, S_DRAIN, S_LUT, S_CELL, S_TANH, S_HID, S_COMMIT
  } eng_state_t;
endpackage

// File: rtl/lstm_dot_acc.sv
module lstm_dot_acc
  import lstm_pkg::*;
#(
  parameter int RV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [RV*DW-1:0]     w_chunk,
  input  logic [RV*DW-1:0]     x_chunk,
  output logic signed [AW-1:0] acc
);
  logic signed [AW-1:0] chunk_sum;

  always_comb begin
    chunk_sum = '0;
    for (int e = 0; e < RV; e++) begin
      chunk_sum = chunk_sum + AW'($signed(w_chunk[e*DW +: DW])) *
                              AW'($signed(x_chunk[e*DW +: DW]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + chunk_sum;
  end

  AST_CLR_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && en)); // R4
endmodule

// File: rtl/lstm_act_addr.sv
module lstm_act_addr
  import lstm_pkg::*;
#(
  parameter int LW    = 8,
  parameter int SHIFT = 4
) (
  input  logic signed [AW-1:0] pre,
  output logic [LW-1:0]        addr
);
  localparam int MAXV = 2**(LW-1) - 1;
  localparam int MINV = -(2**(LW-1));

  logic signed [AW-1:0] scaled;

  always_comb begin
    scaled = pre >>> SHIFT;
    if (scaled > MAXV)      addr = LW'(MAXV);
    else if (scaled < MINV) addr = LW'(MINV);
    else                    addr = scaled[LW-1:0];
  end
endmodule

// File: rtl/lstm_cell_upd.sv
module lstm_cell_upd
  import lstm_pkg::*;
(
  input  logic signed [DW-1:0] g_in,
  input  logic signed [DW-1:0] g_cand,
  input  logic signed [DW-1:0] g_fgt,
  input  logic signed [DW-1:0] c_old,
  output logic [DW-1:0]        c_new
);
  logic signed [AW-1:0] mix;
  logic signed [AW-1:0] mix_sh;

  always_comb begin
    mix    = AW'(g_in) * AW'(g_cand) + AW'(c_old) * AW'(g_fgt);
    mix_sh = mix >>> FRAC;
    c_new  = mix_sh[DW-1:0];
  end
endmodule

// File: rtl/lstm_unit_engine.sv
module lstm_unit_engine
  import lstm_pkg::*;
#(
  parameter int D     = 4,
  parameter int H     = 4,
  parameter int RV    = 2,
  parameter int LW    = 8,
  parameter int SHIFT = 4,
  parameter int SW    = 8,
  localparam int R    = D + H,
  localparam int NCH  = R / RV,
  localparam int HAW  = (H > 1) ? $clog2(H) : 1,
  localparam int CAW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int XAW  = (R > 1) ? $clog2(R) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SW-1:0]        num_steps,
  output logic                 busy,
  output logic                 done,
  output logic [HAW-1:0]       w_row,
  output logic [CAW-1:0]       w_chunk,
  input  logic [NG*RV*DW-1:0]  w_rd_data,
  output logic [HAW-1:0]       b_addr,
  input  logic [NG*DW-1:0]     b_rd_data,
  output logic [NG*LW-1:0]     lut_addr,
  input  logic [NG*DW-1:0]     lut_rd_data,
  output logic [LW-1:0]        tanh_addr,
  input  logic [DW-1:0]        tanh_rd_data,
  output logic [HAW-1:0]       c_rd_addr,
  input  logic [DW-1:0]        c_rd_data,
  output logic                 c_wr_en,
  output logic [HAW-1:0]       c_wr_addr,
  output logic [DW-1:0]        c_wr_data,
  output logic [CAW-1:0]       xh_rd_chunk,
  input  logic [RV*DW-1:0]     xh_rd_data,
  output logic                 xh_wr_en,
  output logic [XAW-1:0]       xh_wr_addr,
  output logic [DW-1:0]        xh_wr_data
);
  eng_state_t state;
  logic [CAW-1:0]       k;
  logic [HAW-1:0]       idx;
  logic [HAW-1:0]       cj;
  logic [SW-1:0]        step;
  logic [SW-1:0]        nsteps_q;
  logic                 vld_q;
  logic                 done_q;
  logic signed [DW-1:0] o_q;
  logic signed [DW-1:0] c_new_q;
  logic [DW-1:0]        shadow [H];

  logic                 acc_clr;
  logic signed [AW-1:0] acc [NG];
  logic signed [AW-1:0] pre [NG];
  logic [DW-1:0]        c_new_w;
  logic signed [AW-1:0] c_new_ext;
  logic signed [AW-1:0] h_prod;
  logic signed [AW-1:0] h_sh;

  assign acc_clr = (state == S_IDLE) || (state == S_HID);

  for (genvar g = 0; g < NG; g++) begin : g_gate
    lstm_dot_acc #(.RV(RV)) u_dot (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr),
      .en      (vld_q),
      .w_chunk (w_rd_data[g*RV*DW +: RV*DW]),
      .x_chunk (xh_rd_data),
      .acc     (acc[g])
    );
    assign pre[g] = (acc[g] >>> FRAC) + AW'($signed(b_rd_data[g*DW +: DW]));
    lstm_act_addr #(.LW(LW), .SHIFT(SHIFT)) u_act (
      .pre  (pre[g]),
      .addr (lut_addr[g*LW +: LW])
    );
  end

  lstm_cell_upd u_cell (
    .g_in   ($signed(lut_rd_data[0*DW +: DW])),
    .g_cand ($signed(lut_rd_data[1*DW +: DW])),
    .g_fgt  ($signed(lut_rd_data[2*DW +: DW])),
    .c_old  ($signed(c_rd_data)),
    .c_new  (c_new_w)
  );

  assign c_new_ext = AW'(c_new_q);
  lstm_act_addr #(.LW(LW), .SHIFT(SHIFT)) u_tanh_act (
    .pre  (c_new_ext),
    .addr (tanh_addr)
  );

  assign h_prod = AW'($signed(tanh_rd_data)) * AW'(o_q);
  assign h_sh   = h_prod >>> FRAC;

  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign w_row       = idx;
  assign w_chunk     = k;
  assign b_addr      = idx;
  assign c_rd_addr   = idx;
  assign xh_rd_chunk = k;
  assign c_wr_en     = (state == S_TANH);
  assign c_wr_addr   = idx;
  assign c_wr_data   = c_new_q;
  assign xh_wr_en    = (state == S_COMMIT);
  assign xh_wr_addr  = XAW'(D) + XAW'(cj);
  assign xh_wr_data  = shadow[cj];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      k        <= '0;
      idx      <= '0;
      cj       <= '0;
      step     <= '0;
      nsteps_q <= '0;
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
      o_q      <= '0;
      c_new_q  <= '0;
      for (int i = 0; i < H; i++) shadow[i] <= '0;
    end else begin
      vld_q  <= (state == S_DOT);
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          nsteps_q <= (num_steps == '0) ? SW'(1) : num_steps;
          step     <= '0;
          idx      <= '0;
          k        <= '0;
          state    <= S_DOT;
        end
        S_DOT: if (k == CAW'(NCH-1)) begin
          k     <= '0;
          state <= S_DRAIN;
        end else begin
          k <= k + 1'b1;
        end
        S_DRAIN: state <= S_LUT;
        S_LUT:   state <= S_CELL;
        S_CELL: begin
          c_new_q <= $signed(c_new_w);
          o_q     <= $signed(lut_rd_data[3*DW +: DW]);
          state   <= S_TANH;
        end
        S_TANH: state <= S_HID;
        S_HID: begin
          shadow[idx] <= h_sh[DW-1:0];
          if (idx == HAW'(H-1)) begin
            cj    <= '0;
            state <= S_COMMIT;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_DOT;
          end
        end
        S_COMMIT: if (cj == HAW'(H-1)) begin
          idx <= '0;
          if (step == nsteps_q - 1'b1) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            step  <= step + 1'b1;
            state <= S_DOT;
          end
        end else begin
          cj <= cj + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
  AST_CELL_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |=> !c_wr_en); // R6
  AST_HIDDEN_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    xh_wr_en |-> (xh_wr_addr >= XAW'(D))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!c_wr_en && !xh_wr_en)); // R10
endmodule

// File: tb/lstm_unit_engine_tb_top.sv
`timescale 1ns/1ps
module lstm_unit_engine_tb_top;
  localparam int D = 4, H = 4, RV = 2, LW = 8, SHIFT = 4, SW = 8;
  localparam int R = D + H, NCH = R / RV;
  localparam int HAW = 2, CAW = 2, XAW = 3, NT = 2**LW;
  localparam int STEP_CYC = H * (NCH + 6);

  logic clk = 0, rst_n = 0, start = 0;
  logic [SW-1:0] num_steps = '0;
  logic busy, done;
  logic [HAW-1:0] w_row, b_addr, c_rd_addr, c_wr_addr;
  logic [CAW-1:0] w_chunk, xh_rd_chunk;
  logic [4*RV*16-1:0] w_rd_data;
  logic [4*16-1:0] b_rd_data, lut_rd_data;
  logic [4*LW-1:0] lut_addr;
  logic [LW-1:0] tanh_addr;
  logic [15:0] tanh_rd_data, c_rd_data, c_wr_data, xh_wr_data;
  logic c_wr_en, xh_wr_en;
  logic [RV*16-1:0] xh_rd_data;
  logic [XAW-1:0] xh_wr_addr;

  always #2 clk = ~clk;

  lstm_unit_engine #(.D(D), .H(H), .RV(RV), .LW(LW), .SHIFT(SHIFT), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num_steps(num_steps),
    .busy(busy), .done(done), .w_row(w_row), .w_chunk(w_chunk),
    .w_rd_data(w_rd_data), .b_addr(b_addr), .b_rd_data(b_rd_data),
    .lut_addr(lut_addr), .lut_rd_data(lut_rd_data), .tanh_addr(tanh_addr),
    .tanh_rd_data(tanh_rd_data), .c_rd_addr(c_rd_addr), .c_rd_data(c_rd_data),
    .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data),
    .xh_rd_chunk(xh_rd_chunk), .xh_rd_data(xh_rd_data), .xh_wr_en(xh_wr_en),
    .xh_wr_addr(xh_wr_addr), .xh_wr_data(xh_wr_data)
  );

  logic signed [15:0] wm [4][H][R];
  logic signed [15:0] bm [4][H];
  logic signed [15:0] lutm [4][NT];
  logic signed [15:0] tanhm [NT];
  logic signed [15:0] cm [H];
  logic signed [15:0] xm [R];
  logic signed [15:0] gc [H];
  logic signed [15:0] gx [R];

  always @(posedge clk) begin
    for (int g = 0; g < 4; g++) begin
      for (int e = 0; e < RV; e++)
        w_rd_data[(g*RV+e)*16 +: 16] <= wm[g][w_row][int'(w_chunk)*RV+e];
      b_rd_data[g*16 +: 16]   <= bm[g][b_addr];
      lut_rd_data[g*16 +: 16] <= lutm[g][lut_addr[g*LW +: LW]];
    end
    for (int e = 0; e < RV; e++)
      xh_rd_data[e*16 +: 16] <= xm[int'(xh_rd_chunk)*RV+e];
    tanh_rd_data <= tanhm[tanh_addr];
    c_rd_data    <= cm[c_rd_addr];
    if (c_wr_en)  cm[c_wr_addr] <= c_wr_data;
    if (xh_wr_en) xm[xh_wr_addr] <= xh_wr_data;
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int tbl_idx(int p);
    int s = p >>> SHIFT;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return s & (NT-1);
  endfunction

  // R4 R5 R6 R7 R8: independent reference of the whole run
  task automatic golden(int steps);
    logic signed [15:0] hn [H];
    logic signed [15:0] gv [4];
    for (int h = 0; h < H; h++) gc[h] = cm[h];
    for (int r = 0; r < R; r++) gx[r] = xm[r];
    for (int s = 0; s < steps; s++) begin
      for (int h = 0; h < H; h++) begin
        int c32, t32;
        for (int g = 0; g < 4; g++) begin
          int acc = 0;
          for (int r = 0; r < R; r++) acc += int'(wm[g][h][r]) * int'(gx[r]);
          acc = (acc >>> 8) + int'(bm[g][h]);
          gv[g] = lutm[g][tbl_idx(acc)];
        end
        c32 = (int'(gv[0]) * int'(gv[1]) + int'(gc[h]) * int'(gv[2])) >>> 8;
        gc[h] = c32[15:0];
        t32 = (int'(tanhm[tbl_idx(int'(gc[h]))]) * int'(gv[3])) >>> 8;
        hn[h] = t32[15:0];
      end
      for (int h = 0; h < H; h++) gx[D+h] = hn[h];
    end
  endtask

  task automatic fill(int mode);
    for (int g = 0; g < 4; g++) begin
      for (int h = 0; h < H; h++) begin
        for (int r = 0; r < R; r++) begin
          if (mode == 0) wm[g][h][r] = 16'($signed($urandom_range(0, 1023)) - 512);
          else if (mode == 1) wm[g][h][r] = 16'($urandom);
          else wm[g][h][r] = (g == 0) ? 16'sh4000 : (g == 1) ? 16'shC000 : 16'sh0000;
        end
        bm[g][h] = (mode == 0) ? 16'($signed($urandom_range(0, 2047)) - 1024) : 16'($urandom);
      end
      for (int a = 0; a < NT; a++) lutm[g][a] = 16'($urandom);
    end
    for (int a = 0; a < NT; a++) tanhm[a] = 16'($urandom);
    for (int h = 0; h < H; h++) cm[h] = 16'($urandom);
    for (int r = 0; r < R; r++)
      xm[r] = (mode == 2) ? 16'sh0400 : 16'($signed($urandom_range(0, 1023)) - 512);
  endtask

  task automatic run(string tag, int steps_in, bit poke);
    int eff = (steps_in == 0) ? 1 : steps_in;
    int cyc = 0;
    golden(eff);
    @(negedge clk);
    start = 1; num_steps = SW'(steps_in);
    @(negedge clk);
    start = 0;
    while (busy && cyc < 20000) begin
      cyc++;
      if (poke && cyc == 7) begin start = 1; num_steps = 8'd9; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    if (cyc >= 20000) chk("R2", {tag, " watchdog"}, cyc, eff*STEP_CYC);
    chk(poke ? "R3" : "R2", {tag, " busy cycles"}, cyc, eff*STEP_CYC);
    chk("R9", {tag, " done at busy fall"}, int'(done), 1);
    @(negedge clk);
    chk("R9", {tag, " done width"}, int'(done), 0);
    for (int h = 0; h < H; h++) begin
      chk(poke ? "R3" : "R6", {tag, " cell"}, int'(cm[h]), int'(gc[h]));
      chk(poke ? "R3" : "R8", {tag, " hidden"}, int'(xm[D+h]), int'(gx[D+h]));
    end
    for (int r = 0; r < D; r++) chk("R8", {tag, " input kept"}, int'(xm[r]), int'(gx[r]));
  endtask

  initial begin
    void'($urandom(32'd2024));
    fill(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "c_wr_en", int'(c_wr_en), 0);
    chk("R1", "xh_wr_en", int'(xh_wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    // R10 idle quiet
    chk("R10", "idle c_wr_en", int'(c_wr_en), 0);
    chk("R10", "idle xh_wr_en", int'(xh_wr_en), 0);
    run("R4 R7 single", 1, 0);
    run("R8 three-step", 3, 0);
    run("R2 zero-steps", 0, 0);
    run("R3 start-while-busy", 2, 1);
    fill(2);
    run("R5 saturate", 1, 0);
    for (int i = 0; i < 4; i++) begin
      fill(i % 2);
      run("R4 random", 1 + (i % 3), 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule